// File: doc/BRIEF.md
# Scalar-read vector-write hazard interlock

This block sits in the issue stage of an in-order instruction stream and guards against one ordering problem. A scalar memory instruction reads scalar registers. If a later vector ALU instruction then writes one of those registers, a harmless scalar ALU instruction must be placed between them. The block records, in a 128-bit scoreboard, which scalar registers scalar memory instructions have read. When a vector ALU instruction arrives whose scalar destinations overlap a marked register, the block holds that instruction for one cycle. In the next cycle it raises a pulse that tells the issue logic to insert a 32-bit scalar move of the constant 0 into the null register ahead of it.

Each instruction arrives as a decoded descriptor. The descriptor gives a class, two source register ranges (base and size), two destination ranges, a wait kind, a wait immediate and a flag that says the destination is the null register. A range of size 0 stands for an absent operand. Descriptors flow under valid/ready. An instruction is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is computed only from the descriptor and the scoreboard, never from `in_valid`. The producer must hold a descriptor stable while `in_ready` is low. Certain scalar instructions and certain wait instructions clear the scoreboard. Every other instruction leaves it untouched.

Top module: `sr_vw_interlock`

## Requirements
- R1: The scoreboard has one bit for each of scalar registers 0..127. Register indices of 128 or above are ignored, both when marking and when checking.
- R2: An accepted scalar memory instruction (class code 1) marks every register from base to base+size-1 of each of its source ranges. A size of 0 marks nothing.
- R3: A vector ALU instruction (class code 2) whose destination ranges cover any marked register is a hazard. It sees `in_ready` low for exactly one cycle. In the following cycle `inject_o` is high for one cycle and `in_ready` is high, so the same instruction is accepted unchanged.
- R4: A hazard clears the whole scoreboard. The vector instruction issued after the injection does not cause a second injection.
- R5: A vector ALU instruction that covers no marked register is accepted at once, with no injection and no scoreboard change. Instructions of class code 0 change nothing.
- R6: An accepted scalar ALU instruction that is not program-control (class code 3) clears the whole scoreboard.
- R7: A program-control instruction (class code 4) with wait kind 1, a dedicated wait on the scalar-memory counter, clears the scoreboard only when its immediate is 0 and the destination-null flag is set.
- R8: A program-control instruction with wait kind 2, a general wait, clears the scoreboard only when immediate bits [13:8] are all 0.
- R9: A program-control instruction with wait kind 0 leaves the scoreboard unchanged.
- R10: Synchronous active-high reset empties the scoreboard and drives `inject_o` low.
- R11: A held vector instruction whose `in_valid` is low causes no injection and no clearing. `inject_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted when high together with in_valid |
| in_class | input | 3 | 0 other, 1 scalar memory, 2 vector ALU, 3 scalar ALU, 4 program-control |
| in_src_base | input | 16 | Two 8-bit source base indices, operand 0 in bits [7:0] |
| in_src_size | input | 8 | Two 4-bit source sizes, operand 0 in bits [3:0] |
| in_dst_base | input | 16 | Two 8-bit scalar destination base indices |
| in_dst_size | input | 8 | Two 4-bit scalar destination sizes |
| in_wait_kind | input | 2 | 0 none, 1 scalar-memory-counter wait, 2 general wait |
| in_wait_imm | input | 16 | Wait immediate |
| in_dst_null | input | 1 | Destination is the null register |
| inject_o | output | 1 | Insert the mitigation move this cycle |

## Verification
The assertions check the handshake timing on every cycle. A stalled valid cycle must be followed by an injection pulse, and an injection must trace back to such a stall. Pulses never come back to back, the cycle after a pulse is always ready, and any class other than vector ALU is always ready, including in the cycle after a scalar ALU clear. Whether a given register was marked or cleared cannot be seen at the ports in a single cycle. The bench's scenarios therefore show that state through later injection decisions. Those scenarios cover range ends, indices above 127, each wait form with its corner immediates, and a randomized stream compared against a reference set.

// File: rtl/srvw_pkg.sv
`timescale 1ns/1ps
package srvw_pkg;
  typedef enum logic [2:0] {
    CLS_OTHER = 3'd0,
    CLS_SMEM  = 3'd1,
    CLS_VALU  = 3'd2,
    CLS_SALU  = 3'd3,
    CLS_PCTL  = 3'd4
  } icls_e;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_SCNT = 2'd1,
    WK_GEN  = 2'd2
  } wkind_e;
endpackage

// File: rtl/srvw_range_mask.sv
`timescale 1ns/1ps
module srvw_range_mask #(
  parameter int NREG  = 128,
  parameter int IDX_W = 8,
  parameter int SZ_W  = 4
) (
  input  logic [IDX_W-1:0] base,
  input  logic [SZ_W-1:0]  size,
  output logic [NREG-1:0]  mask
);
  localparam int SUM_W = IDX_W + 1;

  logic [SUM_W-1:0] lo;
  logic [SUM_W-1:0] hi;

  assign lo = {1'b0, base};
  assign hi = lo + SUM_W'(size);

  // Bits above NREG-1 do not exist, so indices past the file drop out.
  for (genvar r = 0; r < NREG; r++) begin : g_bit
    assign mask[r] = (lo <= SUM_W'(r)) && (SUM_W'(r) < hi);
  end
endmodule

// File: rtl/srvw_clear_decode.sv
`timescale 1ns/1ps
module srvw_clear_decode
  import srvw_pkg::*;
#(
  parameter int IMM_W   = 16,
  parameter int CNT_LSB = 8,
  parameter int CNT_W   = 6
) (
  input  icls_e            cls,
  input  wkind_e           wkind,
  input  logic [IMM_W-1:0] imm,
  input  logic             dst_null,
  output logic             clr
);
  logic cnt_zero;

  assign cnt_zero = (imm[CNT_LSB +: CNT_W] == '0);

  always_comb begin
    clr = 1'b0;
    unique case (cls)
      CLS_SALU: clr = 1'b1;
      CLS_PCTL: begin
        unique case (wkind)
          WK_SCNT: clr = (imm == '0) && dst_null;
          WK_GEN:  clr = cnt_zero;
          default: clr = 1'b0;
        endcase
      end
      default: clr = 1'b0;
    endcase
  end
endmodule

// File: rtl/srvw_scoreboard.sv
`timescale 1ns/1ps
module srvw_scoreboard #(
  parameter int NREG = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            set_en,
  input  logic [NREG-1:0] set_mask,
  output logic [NREG-1:0] marks
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      marks <= '0;
    end else if (set_en) begin
      marks <= marks | set_mask;
    end
  end
endmodule

// File: rtl/sr_vw_interlock.sv
`timescale 1ns/1ps
module sr_vw_interlock
  import srvw_pkg::*;
#(
  parameter int NREG    = 128,
  parameter int IDX_W   = 8,
  parameter int SZ_W    = 4,
  parameter int NSRC    = 2,
  parameter int NDST    = 2,
  parameter int IMM_W   = 16,
  parameter int CNT_LSB = 8,
  parameter int CNT_W   = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [2:0]             in_class,
  input  logic [NSRC*IDX_W-1:0]  in_src_base,
  input  logic [NSRC*SZ_W-1:0]   in_src_size,
  input  logic [NDST*IDX_W-1:0]  in_dst_base,
  input  logic [NDST*SZ_W-1:0]   in_dst_size,
  input  logic [1:0]             in_wait_kind,
  input  logic [IMM_W-1:0]       in_wait_imm,
  input  logic                   in_dst_null,
  output logic                   inject_o
);
  icls_e           cls;
  wkind_e          wkind;
  logic [NREG-1:0] src_part [NSRC];
  logic [NREG-1:0] dst_part [NDST];
  logic [NREG-1:0] src_any;
  logic [NREG-1:0] dst_any;
  logic [NREG-1:0] marks;
  logic            hit;
  logic            hazard;
  logic            accept;
  logic            dec_clr;
  logic            sb_clr;
  logic            sb_set;
  logic            inject_q;

  assign cls   = icls_e'(in_class);
  assign wkind = wkind_e'(in_wait_kind);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    srvw_range_mask #(.NREG(NREG), .IDX_W(IDX_W), .SZ_W(SZ_W)) i_mask (
      .base (in_src_base[s*IDX_W +: IDX_W]),
      .size (in_src_size[s*SZ_W +: SZ_W]),
      .mask (src_part[s])
    );
  end

  for (genvar d = 0; d < NDST; d++) begin : g_dst
    srvw_range_mask #(.NREG(NREG), .IDX_W(IDX_W), .SZ_W(SZ_W)) i_mask (
      .base (in_dst_base[d*IDX_W +: IDX_W]),
      .size (in_dst_size[d*SZ_W +: SZ_W]),
      .mask (dst_part[d])
    );
  end

  always_comb begin
    src_any = '0;
    for (int s = 0; s < NSRC; s++) src_any = src_any | src_part[s];
    dst_any = '0;
    for (int d = 0; d < NDST; d++) dst_any = dst_any | dst_part[d];
  end

  srvw_clear_decode #(.IMM_W(IMM_W), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W)) i_dec (
    .cls      (cls),
    .wkind    (wkind),
    .imm      (in_wait_imm),
    .dst_null (in_dst_null),
    .clr      (dec_clr)
  );

  // Checked against the marks held before this instruction.
  assign hit      = |(dst_any & marks);
  assign hazard   = (cls == CLS_VALU) && hit;
  assign in_ready = !hazard;
  assign accept   = in_valid && in_ready;

  // A hazard empties the scoreboard, so the held instruction passes next cycle.
  assign sb_clr = (in_valid && hazard) || (accept && dec_clr);
  assign sb_set = accept && (cls == CLS_SMEM);

  srvw_scoreboard #(.NREG(NREG)) i_sb (
    .clk      (clk),
    .rst      (rst),
    .clr      (sb_clr),
    .set_en   (sb_set),
    .set_mask (src_any),
    .marks    (marks)
  );

  always_ff @(posedge clk) begin
    if (rst) inject_q <= 1'b0;
    else     inject_q <= in_valid && hazard;
  end

  assign inject_o = inject_q;
endmodule

// File: rtl/srvw_checker.sv
`timescale 1ns/1ps
module srvw_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] in_class,
  input logic       inject_o
);
  a_r3_stall_then_inject: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> inject_o);

  a_r3_inject_has_cause: assert property (@(posedge clk) disable iff (rst)
    inject_o |-> $past(in_valid && !in_ready));

  a_r4_ready_after_inject: assert property (@(posedge clk) disable iff (rst)
    inject_o |-> in_ready);

  a_r11_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    inject_o |=> !inject_o);

  a_r5_only_vector_stalls: assert property (@(posedge clk) disable iff (rst)
    (in_class != 3'd2) |-> in_ready);

  a_r6_salu_empties: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 3'd3) |=> in_ready);
endmodule

bind sr_vw_interlock srvw_checker i_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_class (in_class),
  .inject_o (inject_o)
);

// File: tb/test_sr_vw_interlock.sv
`timescale 1ns/1ps
module test_sr_vw_interlock;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_class = '0;
  logic [15:0] in_src_base = '0;
  logic [7:0]  in_src_size = '0;
  logic [15:0] in_dst_base = '0;
  logic [7:0]  in_dst_size = '0;
  logic [1:0]  in_wait_kind = '0;
  logic [15:0] in_wait_imm = '0;
  logic        in_dst_null = 1'b0;
  logic        inject_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [127:0] model = '0;

  always #2.5 clk = ~clk;

  sr_vw_interlock i_sr_vw_interlock (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_src_base(in_src_base), .in_src_size(in_src_size),
    .in_dst_base(in_dst_base), .in_dst_size(in_dst_size),
    .in_wait_kind(in_wait_kind), .in_wait_imm(in_wait_imm),
    .in_dst_null(in_dst_null), .inject_o(inject_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rmask(input int b, input int s);
    logic [127:0] m = '0;
    for (int i = 0; i < s; i++) if (b + i < 128) m[b + i] = 1'b1;
    return m;
  endfunction

  function automatic bit model_clear(input int c, input int wk, input int imm, input bit nul);
    if (c == 3) return 1'b1;
    if (c == 4 && wk == 1) return (imm == 0) && nul;
    if (c == 4 && wk == 2) return ((imm >> 8) & 8'h3f) == 0;
    return 1'b0;
  endfunction

  task automatic drive(input int c, input int sb0, input int ss0, input int sb1, input int ss1,
                       input int db0, input int ds0, input int db1, input int ds1,
                       input int wk, input int imm, input bit nul);
    in_class     = 3'(c);
    in_src_base  = {8'(sb1), 8'(sb0)};
    in_src_size  = {4'(ss1), 4'(ss0)};
    in_dst_base  = {8'(db1), 8'(db0)};
    in_dst_size  = {4'(ds1), 4'(ds0)};
    in_wait_kind = 2'(wk);
    in_wait_imm  = 16'(imm);
    in_dst_null  = nul;
  endtask

  // One instruction through the handshake, checked against the reference set.
  task automatic send(input string req, input int c, input int sb0, input int ss0,
                      input int sb1, input int ss1, input int db0, input int ds0,
                      input int db1, input int ds1, input int wk, input int imm, input bit nul);
    bit haz;
    @(negedge clk);
    drive(c, sb0, ss0, sb1, ss1, db0, ds0, db1, ds1, wk, imm, nul);
    in_valid = 1'b1;
    #1;
    haz = (c == 2) && |((rmask(db0, ds0) | rmask(db1, ds1)) & model);
    chk(in_ready == !haz, {req, " ready"}, int'(in_ready), int'(!haz));
    chk(inject_o == 1'b0, {req, " no stale inject"}, int'(inject_o), 0);
    if (haz) begin
      model = '0;
      @(negedge clk);
      #1;
      chk(inject_o == 1'b1, {req, " R3 inject pulse"}, int'(inject_o), 1);
      chk(in_ready == 1'b1, {req, " R4 ready after inject"}, int'(in_ready), 1);
    end
    if (c == 1) model = model | rmask(sb0, ss0) | rmask(sb1, ss1);
    if (model_clear(c, wk, imm, nul)) model = '0;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic smem(input int b, input int s);
    send("R2 mark", 1, b, s, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
  endtask

  task automatic valu(input string req, input int b, input int s, input bit exp_haz);
    bit pre = (|(rmask(b, s) & model));
    chk(pre == exp_haz, {req, " directed expectation"}, int'(pre), int'(exp_haz));
    send(req, 2, 0, 0, 0, 0, b, s, 0, 0, 0, 0, 1'b0);
  endtask

  task automatic t_reset;
    #1;
    chk(inject_o == 1'b0, "R10 inject low after reset", int'(inject_o), 0);
    valu("R10 empty scoreboard", 0, 15, 1'b0);
    send("R10 wide valu", 2, 0, 0, 0, 0, 15, 15, 100, 15, 0, 0, 1'b0);
  endtask

  task automatic t_basic;
    smem(10, 1);
    valu("R3 single overlap", 10, 1, 1'b1);
    valu("R4 cleared after hazard", 10, 1, 1'b0);
  endtask

  task automatic t_multi;
    smem(20, 4);
    valu("R5 adjacent miss", 24, 2, 1'b0);
    valu("R2 range top", 23, 1, 1'b1);
    smem(20, 4);
    valu("R2 range bottom overlap", 18, 3, 1'b1);
    send("R2 two sources", 1, 40, 1, 60, 2, 0, 0, 0, 0, 0, 0, 1'b0);
    send("R3 second dest", 2, 0, 0, 0, 0, 0, 0, 61, 1, 0, 0, 1'b0);
  endtask

  task automatic t_edge;
    smem(126, 8);
    valu("R1 index past file", 128, 4, 1'b0);
    valu("R1 last register", 127, 1, 1'b1);
    smem(130, 4);
    valu("R1 high source ignored", 0, 15, 1'b0);
    valu("R1 high dest ignored", 130, 4, 1'b0);
    smem(3, 0);
    valu("R2 zero size marks nothing", 0, 15, 1'b0);
  endtask

  task automatic t_salu;
    smem(5, 1);
    send("R6 scalar alu clears", 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    valu("R6 after clear", 5, 1, 1'b0);
    smem(5, 1);
    send("R5 other class", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    valu("R5 other keeps marks", 5, 1, 1'b1);
  endtask

  task automatic t_scnt;
    smem(7, 1);
    send("R7 imm0 not null", 4, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1'b0);
    valu("R7 kept without null", 7, 1, 1'b1);
    smem(7, 1);
    send("R7 imm1 null", 4, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1'b1);
    valu("R7 kept with nonzero imm", 7, 1, 1'b1);
    smem(7, 1);
    send("R7 imm0 null", 4, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1'b1);
    valu("R7 cleared", 7, 1, 1'b0);
  endtask

  task automatic t_gen;
    smem(9, 1);
    send("R8 field all ones", 4, 0, 0, 0, 0, 0, 0, 0, 0, 2, 'h3F00, 1'b0);
    valu("R8 kept field set", 9, 1, 1'b1);
    smem(9, 1);
    send("R8 field low bit", 4, 0, 0, 0, 0, 0, 0, 0, 0, 2, 'h0100, 1'b0);
    valu("R8 kept bit 8", 9, 1, 1'b1);
    smem(9, 1);
    send("R8 field zero", 4, 0, 0, 0, 0, 0, 0, 0, 0, 2, 'hC0FF, 1'b0);
    valu("R8 cleared", 9, 1, 1'b0);
  endtask

  task automatic t_pnone;
    smem(11, 1);
    send("R9 plain control", 4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    valu("R9 kept", 11, 1, 1'b1);
  endtask

  task automatic t_idle_hold;
    smem(50, 1);
    @(negedge clk);
    drive(2, 0, 0, 0, 0, 50, 1, 0, 0, 0, 0, 1'b0);
    in_valid = 1'b0;
    #1;
    chk(in_ready == 1'b0, "R11 ready low without valid", int'(in_ready), 0);
    @(negedge clk);
    #1;
    chk(inject_o == 1'b0, "R11 no inject without valid", int'(inject_o), 0);
    valu("R11 marks survive idle", 50, 1, 1'b1);
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++) begin
      int c = $urandom_range(0, 4);
      int wk = $urandom_range(0, 2);
      int imm = (wk == 2) ? ($urandom_range(0, 1) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 65535)))
                          : int'($urandom_range(0, 1));
      if (c == 1 || c == 2) c = $urandom_range(1, 2);
      send("R11 random stream", c,
           $urandom_range(0, 135), $urandom_range(0, 4), $urandom_range(0, 135), $urandom_range(0, 4),
           $urandom_range(0, 135), $urandom_range(0, 3), $urandom_range(0, 135), $urandom_range(0, 3),
           wk, imm, 1'($urandom_range(0, 1)));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_basic();
    t_multi();
    t_edge();
    t_salu();
    t_scnt();
    t_gen();
    t_pnone();
    t_idle_hold();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule